// File: doc/BRIEF.md
# Byte-Lane Write Strobe Controller

This block sits between the synchronous control pins of a static RAM and its storage array. On every rising clock edge it samples three chip enables, a global write request, a byte-write enable, one select per byte lane, the address and the write word. It turns them into a registered per-lane write mask, a write-valid flag and the captured address and lane data. The array then runs its own self-timed write cycle from these registers, so no second strobe is needed from outside.

The word is built from byte lanes of nine bits each: eight data bits with one parity bit on top. Lane k occupies word bits [k*9 +: 9], and its parity bit is bit k*9+8. A lane's data and parity are always captured together. The chip is selected only when two active-low enables are low and one active-high enable is high. The global write wins over every byte-level control. A byte write writes only the lanes whose selects are low. Any other selected cycle is a read and writes nothing.

Top module: `wr_lane_ctrl`

## Requirements
- R1: While reset is asserted, and until the first sampled cycle after its release, wr_mask is 0, wr_valid is 0, and wr_addr and wr_data are all zeros.
- R2: In a selected cycle with all_wr_n high and lane_wr_en_n low, wr_mask after the edge equals the bitwise inverse of lane_sel_n (bit k set means lane k is written), and wr_valid is 1 when at least one bit is set.
- R3: In a selected cycle with all_wr_n low, wr_mask becomes all ones and wr_valid becomes 1, whatever lane_wr_en_n and lane_sel_n are.
- R4: The chip is selected only when cs_lo_a_n is 0, cs_lo_b_n is 0 and cs_hi is 1. In any other cycle wr_mask becomes 0, wr_valid becomes 0, and wr_addr and wr_data keep their values, even with all_wr_n low.
- R5: In a selected cycle with all_wr_n high and lane_wr_en_n high (a read), wr_mask becomes 0 and wr_valid becomes 0.
- R6: In a selected cycle with lane_wr_en_n low and every lane_sel_n bit high, wr_mask becomes 0, wr_valid becomes 0, and wr_addr and wr_data are left unchanged.
- R7: On a valid write, each lane whose mask bit is set loads its 9 bits (8 data bits and the parity bit at lane bit 8) from wdata_in into wr_data. Lanes whose mask bit is clear keep their previous contents.
- R8: wr_addr loads addr_in on every cycle where wr_valid becomes 1, and holds its value otherwise.
- R9: The outputs change only at a rising edge and reflect the controls sampled at that edge. The mask of a write is present for exactly one cycle and clears after a following non-write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_lo_a_n | input | 1 | First chip enable, active low |
| cs_lo_b_n | input | 1 | Second chip enable, active low |
| cs_hi | input | 1 | Third chip enable, active high |
| all_wr_n | input | 1 | Global write, active low, writes every lane |
| lane_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane select, active low, bit k for lane k |
| addr_in | input | ADDR_W | Word address |
| wdata_in | input | LANES*(LANE_DATA_W+1) | Write word, lane k at bits [k*9 +: 9] by default |
| wr_mask | output | LANES | Registered per-lane write strobe |
| wr_valid | output | 1 | Registered flag, at least one lane written this cycle |
| wr_addr | output | ADDR_W | Address of the last valid write |
| wr_data | output | LANES*(LANE_DATA_W+1) | Captured lane data including parity bits |

## Verification
The bench builds the block with four lanes of eight data bits plus parity and a 12-bit address. Four lanes are enough to present sparse masks, a single lane, all lanes through byte selects, and the empty-select case. They also make lane-hold visible, because the untouched lanes carry distinct earlier patterns. The parity bit is set to values that differ from the data bits, so a lane-width or lane-offset fault shows up in wr_data. Each chip enable is taken out of its active level on its own while a global write is requested, so every term of the select condition is exercised.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

  // Kind of cycle decoded from the sampled controls
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_READ   = 2'd1,
    CYC_BYTE   = 2'd2,
    CYC_GLOBAL = 2'd3
  } wlc_cyc_e;

endpackage

// File: rtl/wlc_rst_sync.sv
module wlc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wlc_chip_sel.sv
module wlc_chip_sel (
  input  logic cs_lo_a_n,
  input  logic cs_lo_b_n,
  input  logic cs_hi,
  output logic selected
);

  always_comb begin
    selected = (~cs_lo_a_n) & (~cs_lo_b_n) & cs_hi;
  end

endmodule

// File: rtl/wlc_mask_decode.sv
module wlc_mask_decode
  import wlc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             selected,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output wlc_cyc_e         cyc_kind,
  output logic [LANES-1:0] mask_nxt
);

  // Priority: chip select gates all, then global write, then byte write
  always_comb begin
    cyc_kind = CYC_IDLE;
    mask_nxt = '0;
    if (selected) begin
      if (!all_wr_n) begin
        cyc_kind = CYC_GLOBAL;
        mask_nxt = '1;
      end else if (!lane_wr_en_n) begin
        cyc_kind = CYC_BYTE;
        mask_nxt = ~lane_sel_n;
      end else begin
        cyc_kind = CYC_READ;
        mask_nxt = '0;
      end
    end
  end

endmodule

// File: rtl/wlc_lane_reg.sv
module wlc_lane_reg #(
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LANE_W-1:0] d,
  output logic [LANE_W-1:0] q
);

  logic [LANE_W-1:0] q_r;
  logic [LANE_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/wr_lane_ctrl.sv
module wr_lane_ctrl
  import wlc_pkg::*;
#(
  parameter  int LANES       = 4,
  parameter  int LANE_DATA_W = 8,
  parameter  int ADDR_W      = 16,
  localparam int LANE_W      = LANE_DATA_W + 1,
  localparam int WORD_W      = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lo_a_n,
  input  logic              cs_lo_b_n,
  input  logic              cs_hi,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [WORD_W-1:0] wdata_in,
  output logic [LANES-1:0]  wr_mask,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);

  logic             rst_sync_n;
  logic             selected;
  wlc_cyc_e         cyc_kind;
  logic [LANES-1:0] mask_nxt;

  logic [LANES-1:0]  mask_q;
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  wlc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wlc_chip_sel u_chip_sel (
    .cs_lo_a_n (cs_lo_a_n),
    .cs_lo_b_n (cs_lo_b_n),
    .cs_hi     (cs_hi),
    .selected  (selected)
  );

  wlc_mask_decode #(.LANES(LANES)) u_mask_decode (
    .selected     (selected),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .cyc_kind     (cyc_kind),
    .mask_nxt     (mask_nxt)
  );

  // Next-state for the control registers
  always_comb begin
    valid_nxt = 1'b0;
    unique case (cyc_kind)
      CYC_GLOBAL: valid_nxt = 1'b1;
      CYC_BYTE:   valid_nxt = |mask_nxt;
      default:    valid_nxt = 1'b0;
    endcase
    addr_nxt = addr_q;
    if (valid_nxt) begin
      addr_nxt = addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_q  <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      mask_q  <= mask_nxt;
      valid_q <= valid_nxt;
      addr_q  <= addr_nxt;
    end
  end

  // One clock-enabled register per lane: data bits and parity together
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wlc_lane_reg #(.LANE_W(LANE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .load  (mask_nxt[g]),
      .d     (wdata_in[g*LANE_W +: LANE_W]),
      .q     (wr_data[g*LANE_W +: LANE_W])
    );
  end

  assign wr_mask  = mask_q;
  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;

endmodule

// File: rtl/wlc_checker.sv
module wlc_checker #(
  parameter  int LANES       = 4,
  parameter  int LANE_DATA_W = 8,
  parameter  int ADDR_W      = 16,
  localparam int WORD_W      = LANES * (LANE_DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_lo_a_n,
  input logic              cs_lo_b_n,
  input logic              cs_hi,
  input logic              all_wr_n,
  input logic              lane_wr_en_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic [LANES-1:0]  wr_mask,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data
);

  logic chip_on;
  assign chip_on = !cs_lo_a_n && !cs_lo_b_n && cs_hi;

  p_byte_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && all_wr_n && !lane_wr_en_n) |=> (wr_mask == ~$past(lane_sel_n)));

  p_global_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && !all_wr_n) |=> (wr_mask == {LANES{1'b1}} && wr_valid));

  p_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_on) |=> (wr_mask == '0 && !wr_valid));

  p_read_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && all_wr_n && lane_wr_en_n) |=> (wr_mask == '0 && !wr_valid));

  p_lane_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask == '0) |-> $stable(wr_data));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid) |-> $stable(wr_addr));

endmodule

bind wr_lane_ctrl wlc_checker #(
  .LANES       (LANES),
  .LANE_DATA_W (LANE_DATA_W),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cs_lo_a_n    (cs_lo_a_n),
  .cs_lo_b_n    (cs_lo_b_n),
  .cs_hi        (cs_hi),
  .all_wr_n     (all_wr_n),
  .lane_wr_en_n (lane_wr_en_n),
  .lane_sel_n   (lane_sel_n),
  .wr_mask      (wr_mask),
  .wr_valid     (wr_valid),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data)
);

// File: tb/wr_lane_ctrl_tb.sv
`timescale 1ns/1ps
module wr_lane_ctrl_tb;

  localparam int LANES  = 4;
  localparam int LDW    = 8;
  localparam int LW     = LDW + 1;
  localparam int ADDR_W = 12;
  localparam int WORD_W = LANES * LW;

  logic              clk;
  logic              rst_n;
  logic              cs_lo_a_n, cs_lo_b_n, cs_hi;
  logic              all_wr_n, lane_wr_en_n;
  logic [LANES-1:0]  lane_sel_n;
  logic [ADDR_W-1:0] addr_in;
  logic [WORD_W-1:0] wdata_in;
  logic [LANES-1:0]  wr_mask;
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [WORD_W-1:0] exp_data;
  logic [ADDR_W-1:0] exp_addr;

  wr_lane_ctrl #(.LANES(LANES), .LANE_DATA_W(LDW), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cs_lo_a_n(cs_lo_a_n), .cs_lo_b_n(cs_lo_b_n), .cs_hi(cs_hi),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .addr_in(addr_in), .wdata_in(wdata_in),
    .wr_mask(wr_mask), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Build a lane word: lane k gets data byte and parity bit
  function automatic logic [WORD_W-1:0] mk_word(input logic [7:0] seed);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < LANES; k++) begin
      w[k*LW +: LDW]  = seed + 8'(k * 17);
      w[k*LW + LDW]   = k[0] ^ seed[0];
    end
    return w;
  endfunction

  task automatic drive_idle();
    cs_lo_a_n = 1'b0; cs_lo_b_n = 1'b0; cs_hi = 1'b1;
    all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = '1;
    addr_in = '0; wdata_in = '0;
  endtask

  // Apply one cycle of controls at a negedge, then check after the edge
  task automatic run_cycle(input string req,
                           input logic a_n, input logic b_n, input logic hi,
                           input logic gw_n, input logic be_n,
                           input logic [LANES-1:0] sel_n,
                           input logic [ADDR_W-1:0] ad, input logic [WORD_W-1:0] d,
                           input logic [LANES-1:0] exp_mask);
    cs_lo_a_n = a_n; cs_lo_b_n = b_n; cs_hi = hi;
    all_wr_n = gw_n; lane_wr_en_n = be_n; lane_sel_n = sel_n;
    addr_in = ad; wdata_in = d;
    for (int k = 0; k < LANES; k++) begin
      if (exp_mask[k]) exp_data[k*LW +: LW] = d[k*LW +: LW];
    end
    if (exp_mask != '0) exp_addr = ad;
    @(posedge clk);
    @(negedge clk);
    chk(req, "wr_mask",  64'(wr_mask),  64'(exp_mask));
    chk(req, "wr_valid", 64'(wr_valid), 64'(exp_mask != '0));
    chk(req, "wr_data",  64'(wr_data),  64'(exp_data));
    chk(req, "wr_addr",  64'(wr_addr),  64'(exp_addr));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive_idle();
    all_wr_n = 1'b0; addr_in = 12'hABC; wdata_in = mk_word(8'h5A);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "mask in reset",  64'(wr_mask),  64'd0);
    chk("R1", "valid in reset", 64'(wr_valid), 64'd0);
    chk("R1", "data in reset",  64'(wr_data),  64'd0);
    chk("R1", "addr in reset",  64'(wr_addr),  64'd0);
    drive_idle();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "mask after release", 64'(wr_mask), 64'd0);
    chk("R1", "data after release", 64'(wr_data), 64'd0);
    exp_data = '0;
    exp_addr = '0;
  endtask

  task automatic t_byte_write();
    run_cycle("R2", 0, 0, 1, 1, 0, 4'b1010, 12'h101, mk_word(8'h11), 4'b0101);
    run_cycle("R7", 0, 0, 1, 1, 0, 4'b0111, 12'h102, mk_word(8'h22), 4'b1000);
    run_cycle("R8", 0, 0, 1, 1, 0, 4'b1101, 12'h103, mk_word(8'h33), 4'b0010);
    run_cycle("R2", 0, 0, 1, 1, 0, 4'b0000, 12'h104, mk_word(8'h44), 4'b1111);
  endtask

  task automatic t_global();
    run_cycle("R3", 0, 0, 1, 0, 1, 4'b1111, 12'h201, mk_word(8'h61), 4'b1111);
    run_cycle("R3", 0, 0, 1, 0, 0, 4'b0110, 12'h202, mk_word(8'h72), 4'b1111);
  endtask

  task automatic t_deselect();
    run_cycle("R4", 1, 0, 1, 0, 0, 4'b0000, 12'h301, mk_word(8'h81), 4'b0000);
    run_cycle("R4", 0, 1, 1, 0, 0, 4'b0000, 12'h302, mk_word(8'h92), 4'b0000);
    run_cycle("R4", 0, 0, 0, 0, 0, 4'b0000, 12'h303, mk_word(8'hA3), 4'b0000);
  endtask

  task automatic t_read();
    run_cycle("R5", 0, 0, 1, 1, 1, 4'b0000, 12'h401, mk_word(8'hB4), 4'b0000);
  endtask

  task automatic t_no_lane();
    run_cycle("R6", 0, 0, 1, 1, 0, 4'b1111, 12'h501, mk_word(8'hC5), 4'b0000);
  endtask

  task automatic t_latency();
    run_cycle("R9", 0, 0, 1, 1, 0, 4'b1001, 12'h601, mk_word(8'hD6), 4'b0110);
    // New write driven mid-cycle must not show before the edge
    cs_lo_a_n = 0; cs_lo_b_n = 0; cs_hi = 1;
    all_wr_n = 0; lane_wr_en_n = 1; lane_sel_n = '1;
    #2;
    chk("R9", "mask before edge", 64'(wr_mask), 64'(4'b0110));
    drive_idle();
    @(posedge clk);
    @(negedge clk);
    chk("R9", "mask clears after read", 64'(wr_mask), 64'd0);
    chk("R9", "valid clears after read", 64'(wr_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_byte_write();
    t_global();
    t_deselect();
    t_read();
    t_no_lane();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule